// File: doc/BRIEF.md
# Level-Interrupt Message Redirector

The block watches a small group of level-sensitive interrupt lines and converts each fresh assertion into a single outbound message write. The message carries a 6-bit vector as its data and goes to a destination address that software programs. Each line has its own two-word entry in a 32-word redirection table. Software reaches the table only through an indirect pair of registers: it writes a table index into a select register, then reads or writes the chosen word through a window register.

Each line holds a latched request bit. A message is produced only when that bit goes from clear to set. Software acknowledges an interrupt by writing the vector value to an end-of-interrupt register. This clears every latched bit whose entry carries that vector. A line that is still high then latches again and raises a new message.

Destinations are stored in a packed form. The block unpacks each one into a full 64-bit message address before it sends the message. The message port presents one beat at a time with a valid/ready handshake. Requests that arrive while the port is stalled wait in a pending mask and drain lowest line first.

Top module: `irq_redirect`

## Requirements
- R1: After reset the select register reads 0 and no message is valid. For line i, table word 0x10+2i reads 0x1A000+(i+2), which is masked, level and active-low, with vector i+2. Table word 0x11+2i reads the packed form of the default destination 0xFFFA0000, which is 0xA0FF0000. All other table words read 0.
- R2: Register accesses use 8-byte-aligned byte addresses: select at 0x800, window at 0x810, end-of-interrupt at 0x840. A read returns its data on reg_rdata one cycle after the request. Window accesses read or write bits 31:0 of the table word indexed by the select value. Reads of 0x840, and of any other address, return 0.
- R3: A window read while select equals 1 returns the version word 0x00200001 (entry count 32 in bits 31:16, 1 in the low bits).
- R4: A window access with a select value of 32 or more reads as zero, and a write through it changes no table word.
- R5: In a line's control word, bit 16 set masks the line. Bits 5:0 are the vector. Bits 15, 13 and 8 are stored and read back, but they do not change delivery.
- R6: A line latches its request bit when the line is high, its mask bit is clear and its destination word is non-zero. Each clear-to-set transition produces exactly one message whose data is the vector, zero-extended to 32 bits. The message is valid after the second rising edge that samples the line high.
- R7: The latched bit clears when the line is low, masked or has a zero destination. A line that stays high produces no further messages. Taking the line low and then high again produces a new message.
- R8: A write of value v to 0x840 clears the latched bit of every line whose vector equals v, comparing all 64 bits. A line still high afterwards sends one new message.
- R9: The message address is built as follows: bits 63:28 are all ones, bits 27:20 are destination bits 23:16, bits 19:12 are destination bits 31:24, and bits 11:0 are zero.
- R10: While msg_valid is high and msg_ready is low, the address and data stay unchanged. Each accepted handshake delivers one message.
- R11: Requests that are waiting are sent in ascending line-number order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, one cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read request |
| irq_in | input | NUM_IN | Level interrupt lines, active high |
| msg_valid | output | 1 | Message beat valid |
| msg_ready | input | 1 | Consumer accepts the beat |
| msg_addr | output | 64 | Message destination address |
| msg_data | output | 32 | Message data (vector) |

## Verification
The hardest case to reach from the ports is several lines becoming newly latched while the output is stalled. This case exercises the pending mask, the ascending drain order and the hold-stable rule all at once. The bench holds msg_ready low and raises three unmasked lines in the same cycle. It watches the held beat for several cycles, then releases ready and checks the arrival order. The acknowledge-while-high refire case is also reached directly: the bench writes the vector of a line it keeps high. Randomized entries with random flag bits and packed destinations cover the address unpacking.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
    localparam int REG_AW    = 12;
    localparam int REG_DW    = 64;
    localparam int TBL_WORDS = 32;
    localparam int TBL_IW    = $clog2(TBL_WORDS);
    localparam int ENT_BASE  = 16;
    localparam int VEC_W     = 6;
    localparam int VEC_OFS   = 2;
    localparam int B_MASK    = 16;
    localparam int B_LEVEL   = 15;
    localparam int B_POL     = 13;

    localparam logic [REG_AW-1:0] OFS_SEL = 12'h800;
    localparam logic [REG_AW-1:0] OFS_WIN = 12'h810;
    localparam logic [REG_AW-1:0] OFS_EOI = 12'h840;

    localparam logic [31:0] SEL_VERSION = 32'd1;
    localparam logic [63:0] VERSION_WORD = (64'(TBL_WORDS) << 16) | 64'd1;
    localparam logic [31:0] RST_CTL = (32'd1 << B_MASK) | (32'd1 << B_LEVEL) | (32'd1 << B_POL);

    // Pack a plain destination into the stored table format.
    function automatic logic [31:0] dest_pack(input logic [31:0] a);
        return {a[19:12], a[27:20], 16'h0000};
    endfunction

    // Expand a stored destination word into a full message address.
    function automatic logic [63:0] dest_unpack(input logic [31:0] s);
        return {32'hFFFF_FFFF, 4'hF, s[23:16], s[31:24], 12'h000};
    endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_redir_pkg::*;
#(
    parameter int          NUM_IN   = 8,
    parameter logic [31:0] DEF_DEST = 32'hFFFA_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_req,
    input  logic                          reg_we,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [REG_DW-1:0]             reg_wdata,
    output logic [REG_DW-1:0]             reg_rdata,
    output logic [NUM_IN-1:0]             mask_o,
    output logic [NUM_IN-1:0][VEC_W-1:0]  vec_o,
    output logic [NUM_IN-1:0][31:0]       dst_o,
    output logic                          eoi_o,
    output logic [REG_DW-1:0]             eoi_val_o
);
    typedef struct packed {
        logic [31:0]                 sel;
        logic [TBL_WORDS-1:0][31:0]  tbl;
        logic [REG_DW-1:0]           rdata;
        logic                        eoi;
        logic [REG_DW-1:0]           eoi_val;
    } rf_t;

    function automatic logic [TBL_WORDS-1:0][31:0] init_tbl();
        logic [TBL_WORDS-1:0][31:0] t;
        t = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            t[ENT_BASE + 2*i]     = RST_CTL | 32'(i + VEC_OFS);
            t[ENT_BASE + 2*i + 1] = dest_pack(DEF_DEST);
        end
        return t;
    endfunction

    rf_t rf_q, rf_d;
    logic              sel_in_range;
    logic [REG_DW-1:0] rd_val;

    always_comb begin
        rf_d         = rf_q;
        rf_d.eoi     = 1'b0;
        sel_in_range = (rf_q.sel < 32'(TBL_WORDS));
        rd_val       = '0;
        if (reg_addr == OFS_SEL) begin
            rd_val = 64'(rf_q.sel);
        end else if (reg_addr == OFS_WIN) begin
            if (rf_q.sel == SEL_VERSION)
                rd_val = VERSION_WORD;
            else if (sel_in_range)
                rd_val = 64'(rf_q.tbl[rf_q.sel[TBL_IW-1:0]]);
        end
        if (reg_req) begin
            if (reg_we) begin
                if (reg_addr == OFS_SEL) begin
                    rf_d.sel = reg_wdata[31:0];
                end else if (reg_addr == OFS_WIN) begin
                    if (sel_in_range)
                        rf_d.tbl[rf_q.sel[TBL_IW-1:0]] = reg_wdata[31:0];
                end else if (reg_addr == OFS_EOI) begin
                    rf_d.eoi     = 1'b1;
                    rf_d.eoi_val = reg_wdata;
                end
            end else begin
                rf_d.rdata = rd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q.sel     <= '0;
            rf_q.tbl     <= init_tbl();
            rf_q.rdata   <= '0;
            rf_q.eoi     <= 1'b0;
            rf_q.eoi_val <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign reg_rdata = rf_q.rdata;
    assign eoi_o     = rf_q.eoi;
    assign eoi_val_o = rf_q.eoi_val;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_ent
        assign mask_o[g] = rf_q.tbl[ENT_BASE + 2*g][B_MASK];
        assign vec_o[g]  = rf_q.tbl[ENT_BASE + 2*g][VEC_W-1:0];
        assign dst_o[g]  = rf_q.tbl[ENT_BASE + 2*g + 1];
    end

    // R4: window write with an out-of-range select leaves the table untouched
    a_r4_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == OFS_WIN && !sel_in_range) |=> $stable(rf_q.tbl));

    // R2: a write to the select register never alters the table
    a_r2_sel_write_no_table: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == OFS_SEL) |=> $stable(rf_q.tbl));
endmodule

// File: rtl/irq_latch.sv
module irq_latch
    import irq_redir_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IN-1:0]             irq_in,
    input  logic [NUM_IN-1:0]             mask_i,
    input  logic [NUM_IN-1:0][VEC_W-1:0]  vec_i,
    input  logic [NUM_IN-1:0][31:0]       dst_i,
    input  logic                          eoi_i,
    input  logic [REG_DW-1:0]             eoi_val_i,
    input  logic [NUM_IN-1:0]             take_i,
    output logic [NUM_IN-1:0]             pend_o
);
    typedef struct packed {
        logic [NUM_IN-1:0] lat;
        logic [NUM_IN-1:0] pend;
    } lt_t;

    lt_t lt_q, lt_d;
    logic [NUM_IN-1:0] armed, ack_hit;

    always_comb begin
        lt_d = lt_q;
        for (int i = 0; i < NUM_IN; i++) begin
            armed[i]   = irq_in[i] && !mask_i[i] && (dst_i[i] != 32'd0);
            ack_hit[i] = eoi_i && (eoi_val_i == 64'(vec_i[i]));
            lt_d.lat[i]  = armed[i] && !ack_hit[i];
            lt_d.pend[i] = (lt_q.pend[i] && !take_i[i]) ||
                           (armed[i] && !ack_hit[i] && !lt_q.lat[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    assign pend_o = lt_q.pend;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
        // R7: a low line leaves its request bit clear
        a_r7_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_in[g] |=> !lt_q.lat[g]);
        // R6: every fresh latch queues a message
        a_r6_rise_queues: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lt_q.lat[g]) |-> lt_q.pend[g]);
        // R8: a matching acknowledge clears the request bit
        a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_i && eoi_val_i == 64'(vec_i[g])) |=> !lt_q.lat[g]);
    end
endmodule

// File: rtl/irq_msg.sv
module irq_msg
    import irq_redir_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IN-1:0]             pend_i,
    input  logic [NUM_IN-1:0][VEC_W-1:0]  vec_i,
    input  logic [NUM_IN-1:0][31:0]       dst_i,
    input  logic                          msg_ready,
    output logic [NUM_IN-1:0]             take_o,
    output logic                          msg_valid,
    output logic [63:0]                   msg_addr,
    output logic [31:0]                   msg_data
);
    localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    typedef struct packed {
        logic        valid;
        logic [63:0] addr;
        logic [31:0] data;
    } mo_t;

    mo_t mo_q, mo_d;
    logic          load, any;
    logic [IW-1:0] pick;

    always_comb begin
        mo_d   = mo_q;
        load   = !mo_q.valid || msg_ready;
        any    = 1'b0;
        pick   = '0;
        take_o = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                any  = 1'b1;
                pick = IW'(i);
            end
        end
        if (load) begin
            mo_d.valid = any;
            if (any) begin
                take_o[pick] = 1'b1;
                mo_d.addr    = dest_unpack(dst_i[pick]);
                mo_d.data    = 32'(vec_i[pick]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mo_q <= '0;
        else        mo_q <= mo_d;
    end

    assign msg_valid = mo_q.valid;
    assign msg_addr  = mo_q.addr;
    assign msg_data  = mo_q.data;

    // R10: a stalled beat stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    // R11: at most one line is granted per cycle
    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_o));
    // R9: message addresses always carry the all-ones upper field
    a_r9_addr_upper: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[63:28] == '1 && msg_addr[11:0] == '0));
    // R6: message data never exceeds the vector width
    a_r6_data_width: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:VEC_W] == '0));
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
    import irq_redir_pkg::*;
#(
    parameter int          NUM_IN   = 8,
    parameter logic [31:0] DEF_DEST = 32'hFFFA_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_req,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic [NUM_IN-1:0]    irq_in,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [63:0]          msg_addr,
    output logic [31:0]          msg_data
);
    logic [NUM_IN-1:0]             mask_w, pend_w, take_w;
    logic [NUM_IN-1:0][VEC_W-1:0]  vec_w;
    logic [NUM_IN-1:0][31:0]       dst_w;
    logic                          eoi_w;
    logic [REG_DW-1:0]             eoi_val_w;

    irq_regfile #(.NUM_IN(NUM_IN), .DEF_DEST(DEF_DEST)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mask_o    (mask_w),
        .vec_o     (vec_w),
        .dst_o     (dst_w),
        .eoi_o     (eoi_w),
        .eoi_val_o (eoi_val_w)
    );

    irq_latch #(.NUM_IN(NUM_IN)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .mask_i    (mask_w),
        .vec_i     (vec_w),
        .dst_i     (dst_w),
        .eoi_i     (eoi_w),
        .eoi_val_i (eoi_val_w),
        .take_i    (take_w),
        .pend_o    (pend_w)
    );

    irq_msg #(.NUM_IN(NUM_IN)) u_msg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_w),
        .vec_i     (vec_w),
        .dst_i     (dst_w),
        .msg_ready (msg_ready),
        .take_o    (take_w),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    // R1: nothing is sent in the cycle right after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !msg_valid);
endmodule

// File: tb/test_irq_redirect.sv
`timescale 1ns/1ps
module test_irq_redirect;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [N-1:0] irq_in = '0;
    logic        msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0, failures = 0;
    int cap_n = 0;
    logic [63:0] cap_addr [256];
    logic [31:0] cap_data [256];

    always #2 clk = ~clk;

    irq_redirect #(.NUM_IN(N)) i_irq_redirect (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready && cap_n < 256) begin
            cap_addr[cap_n] = msg_addr;
            cap_data[cap_n] = msg_data;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [31:0] pack_dst(input logic [31:0] a);
        return ((a & 32'h0ff0_0000) >> 4) | ((a & 32'h000f_f000) << 12);
    endfunction
    function automatic logic [63:0] exp_addr(input logic [31:0] s);
        logic [63:0] x;
        x = (64'(s) << 4) & 64'h0ff0_0000;
        x = x | ((64'(s) >> 12) & 64'h000f_f000);
        return x | 64'hFFFF_FFFF_F000_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata;
    endtask

    task automatic win_rd(input int idx, output logic [63:0] d);
        wr(12'h800, 64'(idx));
        rd(12'h810, d);
    endtask

    task automatic setup(input int ln, input logic [31:0] ctl, input logic [31:0] dst);
        wr(12'h800, 64'(16 + 2*ln));
        wr(12'h810, 64'(ctl));
        wr(12'h800, 64'(17 + 2*ln));
        wr(12'h810, 64'(dst));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] r;
        int base;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        check(msg_valid == 1'b0, "R1 msg_valid after reset", 64'(msg_valid), 0);
        rd(12'h800, r);
        check(r == 0, "R1 select reset", r, 0);
        for (int i = 0; i < N; i++) begin
            win_rd(16 + 2*i, r);
            check(r == 64'h1A000 + 64'(i + 2), "R1 control word reset", r, 64'h1A000 + 64'(i + 2));
            win_rd(17 + 2*i, r);
            check(r == 64'(pack_dst(32'hFFFA_0000)), "R1 destination reset", r, 64'(pack_dst(32'hFFFA_0000)));
        end
        win_rd(5, r);
        check(r == 0, "R1 spare word reset", r, 0);

        // R3 version word
        win_rd(1, r);
        check(r == 64'h0020_0001, "R3 version", r, 64'h0020_0001);

        // R2 window write/read on spare words, select readback, other address
        for (int k = 0; k < 6; k++) begin
            int idx;
            logic [31:0] v;
            idx = (k == 0) ? 0 : 2 + ($urandom % 14);
            v = $urandom;
            wr(12'h800, 64'(idx));
            wr(12'h810, {32'hDEAD_BEEF, v});
            rd(12'h810, r);
            check(r == 64'(v), "R2 window readback", r, 64'(v));
            rd(12'h800, r);
            check(r == 64'(idx), "R2 select readback", r, 64'(idx));
        end
        rd(12'h840, r);
        check(r == 0, "R2 eoi reads zero", r, 0);

        // R4 out-of-range select
        wr(12'h800, 64'd40);
        wr(12'h810, 64'h1234_5678);
        rd(12'h810, r);
        check(r == 0, "R4 oob window reads zero", r, 0);
        win_rd(16, r);
        check(r == 64'h1A002, "R4 oob write left table", r, 64'h1A002);

        // R5 masked line sends nothing
        irq_in[0] = 1'b1;
        cyc(6);
        check(cap_n == 0, "R5 masked line silent", 64'(cap_n), 0);
        // R5/R6/R9 unmask with flag bits 15,13,8 set, vector 0x2A
        setup(0, 32'h0000_A12A, pack_dst(32'hFFFA_0000));
        cyc(4);
        check(cap_n == 1, "R6 one message on unmask", 64'(cap_n), 1);
        check(cap_data[0] == 32'h2A, "R5 vector data with flags set", 64'(cap_data[0]), 64'h2A);
        check(cap_addr[0] == 64'hFFFF_FFFF_FFFA_0000, "R9 default address", cap_addr[0], 64'hFFFF_FFFF_FFFA_0000);

        // R7 no repeat while held
        cyc(10);
        check(cap_n == 1, "R7 held line no repeat", 64'(cap_n), 1);
        // R6 exact latency on re-raise
        irq_in[0] = 1'b0;
        cyc(2);
        irq_in[0] = 1'b1;
        cyc(1);
        check(msg_valid == 1'b0, "R6 not yet valid after one edge", 64'(msg_valid), 0);
        cyc(1);
        check(msg_valid == 1'b1, "R6 valid after second edge", 64'(msg_valid), 1);
        cyc(3);
        check(cap_n == 2, "R7 new message after low-high", 64'(cap_n), 2);

        // R8 acknowledge with non-matching full value, then matching
        wr(12'h840, 64'h6A);
        cyc(5);
        check(cap_n == 2, "R8 mismatch eoi no effect", 64'(cap_n), 2);
        wr(12'h840, 64'h2A);
        cyc(5);
        check(cap_n == 3, "R8 eoi refires held line", 64'(cap_n), 3);
        check(cap_data[2] == 32'h2A, "R8 refire data", 64'(cap_data[2]), 64'h2A);

        // R7 mask clears latch, unmask refires
        setup(0, 32'h0001_002A, pack_dst(32'hFFFA_0000));
        cyc(3);
        setup(0, 32'h0000_002A, pack_dst(32'hFFFA_0000));
        cyc(4);
        check(cap_n == 4, "R7 mask then unmask refires", 64'(cap_n), 4);
        irq_in[0] = 1'b0;

        // R6 zero destination sends nothing
        setup(1, 32'h0000_0011, 32'h0);
        irq_in[1] = 1'b1;
        cyc(6);
        check(cap_n == 4, "R6 zero destination silent", 64'(cap_n), 4);
        irq_in[1] = 1'b0;
        cyc(2);

        // R10/R11 stalled port with three simultaneous requests
        setup(2, 32'h0000_0012, pack_dst(32'hFEE1_2000));
        setup(5, 32'h0000_0015, pack_dst(32'hFEE5_5000));
        setup(7, 32'h0000_0017, pack_dst(32'hFEE7_7000));
        msg_ready = 1'b0;
        irq_in[2] = 1'b1; irq_in[5] = 1'b1; irq_in[7] = 1'b1;
        cyc(2);
        check(msg_valid && msg_data == 32'h12, "R11 first held beat is lowest line", 64'(msg_data), 64'h12);
        cyc(5);
        check(msg_valid && msg_data == 32'h12 && msg_addr == 64'hFFFF_FFFF_FEE1_2000,
              "R10 beat held stable", msg_addr, 64'hFFFF_FFFF_FEE1_2000);
        base = cap_n;
        msg_ready = 1'b1;
        cyc(6);
        check(cap_n == base + 3, "R10 three handshakes", 64'(cap_n), 64'(base + 3));
        check(cap_data[base] == 32'h12 && cap_data[base+1] == 32'h15 && cap_data[base+2] == 32'h17,
              "R11 ascending order", {cap_data[base+1], cap_data[base+2]}, {32'h15, 32'h17});
        check(cap_addr[base+2] == 64'hFFFF_FFFF_FEE7_7000, "R9 address line 7",
              cap_addr[base+2], 64'hFFFF_FFFF_FEE7_7000);
        irq_in = '0;
        cyc(3);

        // R5/R6/R9 random entries
        for (int it = 0; it < 30; it++) begin
            int ln;
            logic [5:0]  vec;
            logic [31:0] ctl, dst;
            ln  = $urandom % N;
            vec = 6'($urandom);
            ctl = {15'd0, 1'b0, 1'($urandom), 1'b0, 1'($urandom), 4'd0, 1'($urandom), 2'd0, vec};
            dst = $urandom | 32'h0001_0000;
            setup(ln, ctl, dst);
            base = cap_n;
            irq_in[ln] = 1'b1;
            cyc(4);
            check(cap_n == base + 1, "R6 random one message", 64'(cap_n), 64'(base + 1));
            check(cap_data[base] == 32'(vec), "R5 random vector", 64'(cap_data[base]), 64'(vec));
            check(cap_addr[base] == exp_addr(dst), "R9 random address", cap_addr[base], exp_addr(dst));
            irq_in[ln] = 1'b0;
            cyc(2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule